// File: doc/BRIEF.md
# Two-Level 4-to-16 Line Decoder

This block turns a 4-bit select code into sixteen output lines, at most one of them active. Five copies of one small 2-to-4 cell with a gating input form a tree. A root cell decodes the upper two select bits, and each of its four outputs gates one leaf cell. Every leaf cell decodes the lower two select bits into its own group of four lines. A global enable gates the root cell, so clearing it silences the whole tree.

The block is purely combinational: no clock, no reset and no storage. It is used where a 4-bit code must drive one of sixteen strobes, chip selects or write enables. Nothing is held or passed along a stream, so all pins are plain control signals with no valid/ready handshake and no back-pressure. The parameter `ACTIVE_LOW` chooses the output sense. At 0 (the default) the chosen line is high. At 1 every line is inverted, as in a NAND-built decoder, so the chosen line is low and idle lines are high.

Top module: `decoder_tree`

## Requirements
- R1: With `en`=1, output line `y[k]` is in its active state when `sel` equals k, with `sel[3]` as the most significant bit.
- R2: With `en`=0, all sixteen lines are in their inactive state, whatever the value of `sel`.
- R3: For every combination of inputs, no more than one output line is active.
- R4: `sel[3:2]` chooses the group of four lines `y[4g+3:4g]` with g = `sel[3:2]`. With `en`=1, every line outside that group is inactive.
- R5: Within the chosen group, `sel[1:0]` picks the line at offset `sel[1:0]`. The other three lines of the group are inactive.
- R6: With `ACTIVE_LOW`=0, active means 1 and inactive means 0. With `ACTIVE_LOW`=1, active means 0 and inactive means 1, so a disabled decoder drives all ones.
- R7: The outputs follow a change of `en` or `sel` in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Global enable; 0 forces all lines inactive |
| sel | input | 4 | Select code; bit 3 is the most significant |
| y | output | 16 | Decoded lines, sense chosen by `ACTIVE_LOW` |

## Verification
The bench drives all 32 combinations of enable and select code, plus seeded random patterns, into both polarity variants. A design with a miswired root stage would light the correct offset in the wrong group of four. A leaf stage with swapped bits would light the wrong line inside the correct group. A missing gate on the root cell would leave a line active while `en` is low. The inverted variant is checked on its idle level in particular: a design that inverted only the chosen line would drive all zeros when disabled, and the bench catches that. A final check changes `sel` between clock edges to expose any registering of the outputs.

// File: rtl/decoder_tree_pkg.sv
package decoder_tree_pkg;
  // geometry of one cell and of the two-level tree
  parameter int CELL_SEL_W = 2;
  localparam int CELL_OUT_W = 1 << CELL_SEL_W;
  localparam int TREE_SEL_W = 2 * CELL_SEL_W;
  localparam int TREE_OUT_W = 1 << TREE_SEL_W;
  localparam int LEAF_CNT   = CELL_OUT_W;
endpackage

// File: rtl/dec_cell.sv
module dec_cell
  import decoder_tree_pkg::*;
(
  input  logic                  gate,
  input  logic [CELL_SEL_W-1:0] code,
  output logic [CELL_OUT_W-1:0] line
);
  // one line per minterm, all low while the gate is low
  for (genvar i = 0; i < CELL_OUT_W; i++) begin : g_line
    assign line[i] = gate && (code == CELL_SEL_W'(i));
  end
endmodule

// File: rtl/out_polarity.sv
module out_polarity #(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int W          = 16
) (
  input  logic [W-1:0] hot,
  output logic [W-1:0] pin
);
  if (ACTIVE_LOW) begin : g_inv
    assign pin = ~hot;
  end else begin : g_pass
    assign pin = hot;
  end
endmodule

// File: rtl/decoder_tree.sv
module decoder_tree
  import decoder_tree_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                  en,
  input  logic [TREE_SEL_W-1:0] sel,
  output logic [TREE_OUT_W-1:0] y
);
  logic [LEAF_CNT-1:0]   grp_gate;
  logic [TREE_OUT_W-1:0] hot;

  // root stage: upper select bits pick which leaf is gated on
  dec_cell u_root (
    .gate (en),
    .code (sel[TREE_SEL_W-1:CELL_SEL_W]),
    .line (grp_gate)
  );

  // leaf stage: lower select bits shared by every leaf
  for (genvar g = 0; g < LEAF_CNT; g++) begin : g_leaf
    dec_cell u_leaf (
      .gate (grp_gate[g]),
      .code (sel[CELL_SEL_W-1:0]),
      .line (hot[g*CELL_OUT_W +: CELL_OUT_W])
    );
  end

  out_polarity #(.ACTIVE_LOW(ACTIVE_LOW), .W(TREE_OUT_W)) u_pol (
    .hot (hot),
    .pin (y)
  );
endmodule

// File: rtl/decoder_tree_chk.sv
module decoder_tree_chk #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic        en,
  input logic [3:0]  sel,
  input logic [15:0] y
);
  logic [15:0] act;
  logic [15:0] grp_mask;
  assign act      = ACTIVE_LOW ? ~y : y;
  assign grp_mask = 16'hF << {sel[3:2], 2'b00};

  always_comb begin
    // R3
    at_most_one_chk: assert ($onehot0(act));
    // R2
    idle_chk: assert (en || act == 16'h0);
    // R1
    hit_chk: assert (!en || act[sel]);
    // R4
    group_chk: assert (!en || (act & ~grp_mask) == 16'h0);
    // R6
    idle_level_chk: assert (en || y == (ACTIVE_LOW ? 16'hFFFF : 16'h0000));
  end
endmodule

bind decoder_tree decoder_tree_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .en  (en),
  .sel (sel),
  .y   (y)
);

// File: tb/tb_decoder_tree.sv
module tb_decoder_tree;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        en;
  logic [3:0]  sel;
  logic [15:0] y, y_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  decoder_tree #(.ACTIVE_LOW(1'b0)) dut   (.en(en), .sel(sel), .y(y));
  decoder_tree #(.ACTIVE_LOW(1'b1)) dut_n (.en(en), .sel(sel), .y(y_n));

  function automatic logic [15:0] exp_y(input logic e, input logic [3:0] s, input bit low);
    logic [15:0] h;
    h = e ? (16'h1 << s) : 16'h0;
    return low ? ~h : h;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s en=%0b sel=%0d actual=%h expected=%h", req, en, sel, act, exp);
    end
  endtask

  // drive at falling edge, sample 2 ns later
  task automatic apply(input logic e, input logic [3:0] s, input string req);
    @(negedge clk);
    en = e; sel = s;
    #2;
    check({req, " hi"}, y, exp_y(e, s, 1'b0));
    check({req, " lo"}, y_n, exp_y(e, s, 1'b1));
    checks++;
    if (!$onehot0(y) || !$onehot0(~y_n)) begin
      fails++;
      $display("FAIL R3 en=%0b sel=%0d actual=%h/%h expected=onehot0", e, s, y, y_n);
    end
  endtask

  initial begin
    en = 1'b0; sel = 4'h0;
    void'($urandom(32'd2024));
    // R2 R6: idle state
    apply(1'b0, 4'h0, "R2 R6 idle");
    // R1 R4 R5 R6: all 32 combinations
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 16; s++)
        apply(e[0], s[3:0], e ? "R1 R4 R5" : "R2");
    // corners: group boundaries
    apply(1'b1, 4'b0011, "R5 edge");
    apply(1'b1, 4'b0100, "R4 edge");
    apply(1'b1, 4'b1111, "R1 top");
    apply(1'b0, 4'b1111, "R2 R6 top off");
    // random mix
    for (int i = 0; i < 60; i++)
      apply(1'(($urandom % 4) != 0), 4'($urandom), "R1 R2 random");
    // R7: change between edges, no clock edge before sampling
    @(posedge clk); #1;
    en = 1'b1; sel = 4'h9; #1;
    check("R7 hi", y, exp_y(1'b1, 4'h9, 1'b0));
    sel = 4'h6; #1;
    check("R7 lo", y_n, exp_y(1'b1, 4'h6, 1'b1));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule